// File: doc/BRIEF.md
# Serial NOR Program and Erase Sequencer

This block drives an SPI transfer engine to carry out program, erase and
initialisation requests against a serial NOR flash. The caller pulses a start
strobe with a request kind, a byte address and a byte length. The sequencer
validates the request. It then breaks it into flash commands and hands them one
at a time to the transfer engine over a request/acknowledge handshake. Each
handshake carries an opcode, an address-present flag, an address and a data
byte count. The block finishes with a single-cycle done pulse and an error flag.

A program request is cut into chunks that never cross a page boundary. An erase
request becomes one chip-erase command when it covers the whole device.
Otherwise it becomes a run of erase steps, each the largest supported size to
which both the current address and the remaining length are aligned. Every
program or erase command is preceded by its own write enable. It is followed by
status reads until the write-in-progress bit clears. A write disable closes
every program and erase sequence. The program data bytes themselves travel from
the caller to the engine outside this block.

Top module: `nor_seq`

## Requirements
- R1: A program or erase request whose address is at or beyond the device size, or whose length runs past the last device byte, completes with done and err set and issues no transfer. A range that ends exactly at the last byte is accepted.
- R2: A request with a valid address and zero length completes with done and err clear and issues no transfer.
- R3: A nonzero erase request whose address or length is not a multiple of 4096 completes with err set and issues no transfer.
- R4: Program commands use opcode 0x38 with an address. Each carries min(remaining, PAGE_BYTES - address mod PAGE_BYTES) bytes, and consecutive chunks start where the previous one ended.
- R5: Every program, erase or status-write command is issued directly after a write enable (0x06, no address, 0 bytes). It is followed by status reads (0x05, 1 byte, xfer_read high), repeated until bit 0 of the returned byte is clear.
- R6: For a partial-device erase, each step uses 64 KiB (0xD8), 32 KiB (0x52) or 4 KiB (0x20). The size chosen is the largest one to which both the current address and the remaining length are aligned, and the steps cover the request exactly.
- R7: An erase of the whole device (address 0, length equal to the device size) issues a single chip erase (0xC7) with no address.
- R8: Every accepted nonzero program or erase sequence ends with a write disable (0x04) before done. done is a one-cycle pulse, and no transfer is requested while done is high.
- R9: An init request (kind 2) issues write enable, then a status write (0x01, no address, 1 byte, data 0x40), then the status polls. It then completes without a write disable.
- R10: A start strobe while busy is high is ignored. It produces no transfers and no extra done pulse.
- R11: Once xfer_req is raised, it and its opcode, address and count stay stable until xfer_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe, sampled while idle |
| req_kind | input | 2 | 0 program, 1 erase, 2 init |
| req_addr | input | REQ_W | Byte address of the request |
| req_len | input | REQ_W | Byte length of the request |
| busy | output | 1 | Sequencer is not idle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error result, valid with done |
| xfer_req | output | 1 | Transfer request to the engine |
| xfer_opcode | output | 8 | Flash opcode of the transfer |
| xfer_has_addr | output | 1 | Transfer carries an address phase |
| xfer_addr | output | AW | Flash address of the transfer |
| xfer_len | output | XLW | Data byte count of the transfer |
| xfer_read | output | 1 | Data phase is a read |
| xfer_wdata | output | 8 | Data byte for a status write |
| xfer_ack | input | 1 | Engine completed the current transfer |
| xfer_rdata | input | 8 | Byte read by the completed transfer |

## Verification
The bench targets program chunks that start mid-page and single-byte chunks on
either side of a boundary. A wrong chunk formula shows up as a chunk that
crosses a page or a length sum that misses the request. Erase runs that must
mix 32 KiB and 64 KiB steps are checked, because a selector that looks only at
the address would overrun the request. A whole-device erase is checked, since a
broken chip-erase match would produce 256 block erases. Range checks are tested
at the exact device end and one byte past it, where an off-by-one would either
reject a legal request or send traffic outside the device. Busy polling is
checked against a flash that reports busy twice, so a sequencer that polls once
would show too few status reads. A start strobe arriving mid-sequence must leave
no trace in the traffic.

// File: rtl/nor_seq_pkg.sv
`timescale 1ns/1ps
package nor_seq_pkg;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_QPP   = 8'h38;
  localparam logic [7:0] OPC_SE4K  = 8'h20;
  localparam logic [7:0] OPC_BE32K = 8'h52;
  localparam logic [7:0] OPC_BE64K = 8'hD8;
  localparam logic [7:0] OPC_CE    = 8'hC7;

  localparam logic [7:0] QE_STATUS = 8'h40;
  localparam int NUM_ERASE = 3;
  localparam int MIN_ERASE_LOG2 = 12;

  typedef enum logic [1:0] {
    REQ_PROG  = 2'd0,
    REQ_ERASE = 2'd1,
    REQ_INIT  = 2'd2
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_WEN, ST_CMD, ST_POLL, ST_WDI, ST_DONE
  } seq_state_e;

  // erase sizes, largest first (index order is the selection priority)
  function automatic int unsigned erase_log2(int idx);
    case (idx)
      0:       return 16;
      1:       return 15;
      default: return 12;
    endcase
  endfunction

  function automatic logic [7:0] erase_opc(int idx);
    case (idx)
      0:       return OPC_BE64K;
      1:       return OPC_BE32K;
      default: return OPC_SE4K;
    endcase
  endfunction

endpackage

// File: rtl/nor_seq_check.sv
`timescale 1ns/1ps
module nor_seq_check
  import nor_seq_pkg::*;
#(
  parameter int          REQ_W     = 32,
  parameter int unsigned DEV_BYTES = 32'h0100_0000
) (
  input  logic [1:0]       kind,
  input  logic [REQ_W-1:0] addr,
  input  logic [REQ_W-1:0] len,
  output logic             reject,
  output logic             empty
);
  localparam logic [REQ_W:0] DEV = (REQ_W+1)'(DEV_BYTES);
  localparam logic [REQ_W-1:0] ALIGN_MASK = REQ_W'((64'd1 << MIN_ERASE_LOG2) - 64'd1);

  logic [REQ_W:0] addr_w, len_w, room;
  logic           range_bad, align_bad, is_init, is_erase, len_zero;

  always_comb begin
    addr_w    = {1'b0, addr};
    len_w     = {1'b0, len};
    room      = DEV - addr_w;
    is_init   = (kind == REQ_INIT);
    is_erase  = (kind == REQ_ERASE);
    len_zero  = (len == '0);
    range_bad = (addr_w >= DEV) || (len_w > room);
    align_bad = is_erase && !len_zero &&
                (((addr & ALIGN_MASK) != '0) || ((len & ALIGN_MASK) != '0));
    reject    = !is_init && (range_bad || align_bad);
    empty     = !is_init && !range_bad && len_zero;
  end

endmodule

// File: rtl/nor_seq_chunk.sv
`timescale 1ns/1ps
module nor_seq_chunk #(
  parameter int PAGE_BYTES = 256,
  parameter int CW         = 25
) (
  input  logic [$clog2(PAGE_BYTES)-1:0] addr_lo,
  input  logic [CW-1:0]                 rem,
  output logic [$clog2(PAGE_BYTES):0]   chunk
);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int XLW = PW + 1;

  logic [XLW-1:0] to_bound;

  always_comb begin
    to_bound = XLW'(PAGE_BYTES) - {1'b0, addr_lo};
    if (rem < CW'(to_bound)) chunk = XLW'(rem);
    else                     chunk = to_bound;
  end

endmodule

// File: rtl/nor_seq_erase_pick.sv
`timescale 1ns/1ps
module nor_seq_erase_pick
  import nor_seq_pkg::*;
#(
  parameter int CW = 25
) (
  input  logic [CW-1:0] addr,
  input  logic [CW-1:0] rem,
  output logic          found,
  output logic [7:0]    opc,
  output logic [CW-1:0] size
);
  logic [NUM_ERASE-1:0] fit;

  for (genvar g = 0; g < NUM_ERASE; g++) begin : g_fit
    localparam logic [CW-1:0] MASK = CW'((64'd1 << erase_log2(g)) - 64'd1);
    assign fit[g] = ((addr & MASK) == '0) && ((rem & MASK) == '0);
  end

  always_comb begin
    found = 1'b0;
    opc   = OPC_SE4K;
    size  = CW'(64'd1 << MIN_ERASE_LOG2);
    // walk smallest to largest so the largest fitting size wins
    for (int i = NUM_ERASE - 1; i >= 0; i--) begin
      if (fit[i]) begin
        found = 1'b1;
        opc   = erase_opc(i);
        size  = CW'(64'd1 << erase_log2(i));
      end
    end
  end

endmodule

// File: rtl/nor_seq.sv
`timescale 1ns/1ps
module nor_seq
  import nor_seq_pkg::*;
#(
  parameter int          PAGE_BYTES = 256,
  parameter int unsigned DEV_BYTES  = 32'h0100_0000,
  parameter int          REQ_W      = 32,
  localparam int         AW         = $clog2(DEV_BYTES),
  localparam int         CW         = AW + 1,
  localparam int         PW         = $clog2(PAGE_BYTES),
  localparam int         XLW        = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic [1:0]       req_kind,
  input  logic [REQ_W-1:0] req_addr,
  input  logic [REQ_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             xfer_req,
  output logic [7:0]       xfer_opcode,
  output logic             xfer_has_addr,
  output logic [AW-1:0]    xfer_addr,
  output logic [XLW-1:0]   xfer_len,
  output logic             xfer_read,
  output logic [7:0]       xfer_wdata,
  input  logic             xfer_ack,
  input  logic [7:0]       xfer_rdata
);

  seq_state_e     state_q, state_d;
  req_kind_e      kind_q, kind_d;
  logic [CW-1:0]  addr_q, addr_d, rem_q, rem_d, size_q, size_d;
  logic [7:0]     opc_q, opc_d;
  logic [XLW-1:0] slen_q, slen_d;
  logic           sha_q, sha_d, err_q, err_d;
  logic           ld_en;

  logic           chk_reject, chk_empty;
  logic [XLW-1:0] chunk;
  logic           er_found;
  logic [7:0]     er_opc;
  logic [CW-1:0]  er_size;
  logic           whole_dev;

  nor_seq_check #(.REQ_W(REQ_W), .DEV_BYTES(DEV_BYTES)) u_check (
    .kind(req_kind), .addr(req_addr), .len(req_len),
    .reject(chk_reject), .empty(chk_empty)
  );

  nor_seq_chunk #(.PAGE_BYTES(PAGE_BYTES), .CW(CW)) u_chunk (
    .addr_lo(addr_q[PW-1:0]), .rem(rem_q), .chunk(chunk)
  );

  nor_seq_erase_pick #(.CW(CW)) u_pick (
    .addr(addr_q), .rem(rem_q),
    .found(er_found), .opc(er_opc), .size(er_size)
  );

  assign whole_dev = (addr_q == '0) && (rem_q == CW'(DEV_BYTES));

  // next-state logic
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    size_d  = size_q;
    opc_d   = opc_q;
    slen_d  = slen_q;
    sha_d   = sha_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (req_start) begin
          kind_d = req_kind_e'(req_kind);
          err_d  = 1'b0;
          if (chk_reject) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else if (chk_empty) begin
            state_d = ST_DONE;
          end else begin
            addr_d  = (req_kind == REQ_INIT) ? '0 : req_addr[CW-1:0];
            rem_d   = (req_kind == REQ_INIT) ? CW'(1) : req_len[CW-1:0];
            state_d = ST_PICK;
          end
        end
      end
      ST_PICK: begin
        if (rem_q == '0) begin
          state_d = (kind_q == REQ_INIT) ? ST_DONE : ST_WDI;
        end else begin
          state_d = ST_WEN;
          case (kind_q)
            REQ_PROG: begin
              opc_d = OPC_QPP; sha_d = 1'b1; slen_d = chunk; size_d = CW'(chunk);
            end
            REQ_ERASE: begin
              slen_d = '0;
              if (whole_dev) begin
                opc_d = OPC_CE; sha_d = 1'b0; size_d = rem_q;
              end else if (er_found) begin
                opc_d = er_opc; sha_d = 1'b1; size_d = er_size;
              end else begin
                err_d   = 1'b1;
                state_d = ST_WDI;
              end
            end
            default: begin
              opc_d = OPC_WRSR; sha_d = 1'b0; slen_d = XLW'(1); size_d = CW'(1);
            end
          endcase
        end
      end
      ST_WEN:  if (xfer_ack) state_d = ST_CMD;
      ST_CMD: begin
        if (xfer_ack) begin
          addr_d  = addr_q + size_q;
          rem_d   = rem_q - size_q;
          state_d = ST_POLL;
        end
      end
      ST_POLL: if (xfer_ack && !xfer_rdata[0]) state_d = ST_PICK;
      ST_WDI:  if (xfer_ack) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ld_en = (state_q != state_d) || (state_q == ST_IDLE);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= REQ_PROG;
      addr_q  <= '0;
      rem_q   <= '0;
      size_q  <= '0;
      opc_q   <= '0;
      slen_q  <= '0;
      sha_q   <= 1'b0;
      err_q   <= 1'b0;
    end else if (ld_en) begin
      state_q <= state_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      size_q  <= size_d;
      opc_q   <= opc_d;
      slen_q  <= slen_d;
      sha_q   <= sha_d;
      err_q   <= err_d;
    end
  end

  // transfer interface, decoded from registered state
  always_comb begin
    xfer_req      = 1'b0;
    xfer_opcode   = 8'h00;
    xfer_has_addr = 1'b0;
    xfer_addr     = '0;
    xfer_len      = '0;
    xfer_read     = 1'b0;
    xfer_wdata    = 8'h00;
    case (state_q)
      ST_WEN: begin xfer_req = 1'b1; xfer_opcode = OPC_WREN; end
      ST_WDI: begin xfer_req = 1'b1; xfer_opcode = OPC_WRDI; end
      ST_POLL: begin
        xfer_req = 1'b1; xfer_opcode = OPC_RDSR; xfer_len = XLW'(1); xfer_read = 1'b1;
      end
      ST_CMD: begin
        xfer_req      = 1'b1;
        xfer_opcode   = opc_q;
        xfer_has_addr = sha_q;
        xfer_addr     = sha_q ? addr_q[AW-1:0] : '0;
        xfer_len      = slen_q;
        xfer_wdata    = (kind_q == REQ_INIT) ? QE_STATUS : 8'h00;
      end
      default: ;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE);
  assign err  = (state_q == ST_DONE) && err_q;

endmodule

// File: rtl/nor_seq_sva.sv
`timescale 1ns/1ps
module nor_seq_sva #(
  parameter int AW  = 24,
  parameter int XLW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           req_start,
  input logic           xfer_req,
  input logic           xfer_ack,
  input logic [7:0]     xfer_opcode,
  input logic           xfer_has_addr,
  input logic [AW-1:0]  xfer_addr,
  input logic [XLW-1:0] xfer_len,
  input logic [7:0]     xfer_wdata
);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_opcode) &&
                                 $stable(xfer_addr) && $stable(xfer_len)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_req);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xfer_req);

  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !busy) |=> busy);

  a_r9_status_value: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_opcode == 8'h01) |->
      (xfer_wdata == 8'h40 && xfer_len == XLW'(1) && !xfer_has_addr));

  a_r7_chip_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_opcode == 8'hC7) |-> !xfer_has_addr);

endmodule

bind nor_seq nor_seq_sva #(.AW(AW), .XLW(XLW)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .req_start(req_start),
  .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_opcode(xfer_opcode),
  .xfer_has_addr(xfer_has_addr), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
  .xfer_wdata(xfer_wdata)
);

// File: tb/nor_seq_tb.sv
`timescale 1ns/1ps
module nor_seq_tb;
  import nor_seq_pkg::*;

  localparam int DEV  = 32'h0100_0000;
  localparam int PAGE = 256;
  localparam int AW   = 24;
  localparam int XLW  = 9;
  localparam int LOGN = 64;

  logic clk, rst_n, req_start, busy, done, err;
  logic [1:0] req_kind;
  logic [31:0] req_addr, req_len;
  logic xfer_req, xfer_has_addr, xfer_read, xfer_ack;
  logic [7:0] xfer_opcode, xfer_wdata, xfer_rdata;
  logic [AW-1:0] xfer_addr;
  logic [XLW-1:0] xfer_len;

  int n_run, n_fail;

  nor_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done), .err(err),
    .xfer_req(xfer_req), .xfer_opcode(xfer_opcode), .xfer_has_addr(xfer_has_addr),
    .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_read(xfer_read),
    .xfer_wdata(xfer_wdata), .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- transfer engine and flash model ----------------
  int cnt, wip_left, log_n, done_cnt;
  logic [7:0]     l_op [LOGN];
  logic [AW-1:0]  l_ad [LOGN];
  logic [XLW-1:0] l_ln [LOGN];
  logic           l_ha [LOGN];
  logic           l_rd [LOGN];
  logic [7:0]     l_wd [LOGN];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_ack   <= 1'b0;
      xfer_rdata <= 8'h00;
      cnt        <= 0;
      wip_left   <= 0;
    end else begin
      xfer_ack <= 1'b0;
      if (xfer_req && xfer_ack) begin
        if (log_n < LOGN) begin
          l_op[log_n] = xfer_opcode;   l_ad[log_n] = xfer_addr;
          l_ln[log_n] = xfer_len;      l_ha[log_n] = xfer_has_addr;
          l_rd[log_n] = xfer_read;     l_wd[log_n] = xfer_wdata;
        end
        log_n = log_n + 1;
        if (xfer_opcode != OPC_WREN && xfer_opcode != OPC_WRDI && xfer_opcode != OPC_RDSR)
          wip_left <= 2;
      end
      if (xfer_req && !xfer_ack) begin
        if (cnt == 1) begin
          xfer_ack <= 1'b1;
          cnt      <= 0;
          if (xfer_opcode == OPC_RDSR && wip_left > 0) begin
            xfer_rdata <= 8'h03;
            wip_left   <= wip_left - 1;
          end else begin
            xfer_rdata <= 8'h02;
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

  always @(posedge clk) if (rst_n && done) done_cnt = done_cnt + 1;

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  logic got_err;

  task automatic run_req(input logic [1:0] k, input logic [31:0] a, input logic [31:0] l);
    int w;
    @(negedge clk);
    log_n     = 0;
    req_kind  = k;
    req_addr  = a;
    req_len   = l;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    check(done == 1'b1, "R8 done seen", done, 1);
    got_err = err;
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  function automatic longint erase_bytes(input logic [7:0] op);
    case (op)
      OPC_SE4K:  return 64'h1000;
      OPC_BE32K: return 64'h8000;
      OPC_BE64K: return 64'h10000;
      OPC_CE:    return DEV;
      default:   return 0;
    endcase
  endfunction

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] len;
    logic        err;
    logic [7:0]  ncmd;
    logic [7:0]  fop;
    logic [31:0] faddr;
    logic [31:0] flen;
    logic [7:0]  lop;
    logic [31:0] llen;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h10,       32'h200,     1'b0, 8'd3, 8'h38, 32'h10,       32'hF0,  8'h38, 32'h10,  8'd4}, // R4 mid-page start
    '{2'd0, 32'h100,      32'h100,     1'b0, 8'd1, 8'h38, 32'h100,      32'h100, 8'h38, 32'h100, 8'd4}, // R4 full page
    '{2'd0, 32'hFFFFF0,   32'h10,      1'b0, 8'd1, 8'h38, 32'hFFFFF0,   32'h10,  8'h38, 32'h10,  8'd1}, // R1 ends at device end
    '{2'd0, 32'hFFFFF0,   32'h11,      1'b1, 8'd0, 8'h00, 32'h0,        32'h0,   8'h00, 32'h0,   8'd1}, // R1 one past end
    '{2'd0, 32'h1000000,  32'h1,       1'b1, 8'd0, 8'h00, 32'h0,        32'h0,   8'h00, 32'h0,   8'd1}, // R1 address outside
    '{2'd0, 32'h5,        32'h0,       1'b0, 8'd0, 8'h00, 32'h0,        32'h0,   8'h00, 32'h0,   8'd2}, // R2 empty program
    '{2'd1, 32'h10000,    32'h30000,   1'b0, 8'd3, 8'hD8, 32'h10000,    32'h0,   8'hD8, 32'h0,   8'd6}, // R6 64K run
    '{2'd1, 32'h8000,     32'h18000,   1'b0, 8'd2, 8'h52, 32'h8000,     32'h0,   8'hD8, 32'h0,   8'd6}, // R6 32K then 64K
    '{2'd1, 32'h3000,     32'h2000,    1'b0, 8'd2, 8'h20, 32'h3000,     32'h0,   8'h20, 32'h0,   8'd6}, // R6 4K steps
    '{2'd1, 32'h1800,     32'h1000,    1'b1, 8'd0, 8'h00, 32'h0,        32'h0,   8'h00, 32'h0,   8'd3}, // R3 addr misaligned
    '{2'd1, 32'h1000,     32'h1800,    1'b1, 8'd0, 8'h00, 32'h0,        32'h0,   8'h00, 32'h0,   8'd3}, // R3 len misaligned
    '{2'd1, 32'h0,        32'h1000000, 1'b0, 8'd1, 8'hC7, 32'h0,        32'h0,   8'hC7, 32'h0,   8'd7}, // R7 chip erase
    '{2'd1, 32'h1000,     32'h0,       1'b0, 8'd0, 8'h00, 32'h0,        32'h0,   8'h00, 32'h0,   8'd2}, // R2 empty erase
    '{2'd1, 32'hFFF000,   32'h2000,    1'b1, 8'd0, 8'h00, 32'h0,        32'h0,   8'h00, 32'h0,   8'd1}, // R1 erase past end
    '{2'd2, 32'h0,        32'h0,       1'b0, 8'd1, 8'h01, 32'h0,        32'h1,   8'h01, 32'h1,   8'd9}, // R9 init
    '{2'd0, 32'hFF,       32'h2,       1'b0, 8'd2, 8'h38, 32'hFF,       32'h1,   8'h38, 32'h1,   8'd4}  // R4 straddles boundary
  };

  task automatic analyze(input vec_t t, input int vi);
    string tg;
    bit wrdi;
    int total, base;
    longint sum, nxt, sz;
    logic [7:0] m;
    tg = $sformatf("R%0d vec%0d", t.rq, vi);
    wrdi  = !t.err && (t.len != 0) && (t.op != 2'd2);
    total = int'(t.ncmd) * 5 + (wrdi ? 1 : 0);
    check(got_err == t.err, {tg, " err"}, got_err, t.err);
    check(log_n == total, {tg, " transfer count (R1 R2 R3 no traffic)"}, log_n, total);
    if (log_n != total || total == 0) return;
    sum = 0;
    nxt = t.addr;
    for (int b = 0; b < int'(t.ncmd); b++) begin
      base = b * 5;
      m = l_op[base+1];
      check(l_op[base] == OPC_WREN && l_ln[base] == 0 && !l_ha[base],
            {tg, " R5 write enable first"}, l_op[base], OPC_WREN);
      for (int p = 2; p < 5; p++)
        check(l_op[base+p] == OPC_RDSR && l_ln[base+p] == 1 && l_rd[base+p],
              {tg, " R5 status poll"}, l_op[base+p], OPC_RDSR);
      if (t.op == 2'd0) begin
        check(m == OPC_QPP && l_ha[base+1], {tg, " R4 program opcode"}, m, OPC_QPP);
        check(longint'(l_ad[base+1]) == nxt, {tg, " R4 chunk address"}, l_ad[base+1], nxt);
        check((l_ad[base+1] % PAGE) + l_ln[base+1] <= PAGE, {tg, " R4 page clip"},
              (l_ad[base+1] % PAGE) + l_ln[base+1], PAGE);
        sz = l_ln[base+1];
      end else if (t.op == 2'd1) begin
        sz = erase_bytes(m);
        check(sz != 0, {tg, " R6 erase opcode"}, m, 8'h20);
        if (m != OPC_CE) begin
          check(longint'(l_ad[base+1]) == nxt && l_ha[base+1], {tg, " R6 erase address"},
                l_ad[base+1], nxt);
          check(sz != 0 && (nxt % sz) == 0, {tg, " R6 alignment"}, nxt, sz);
        end
      end else begin
        check(l_wd[base+1] == QE_STATUS && l_ln[base+1] == 1, {tg, " R9 status data"},
              l_wd[base+1], QE_STATUS);
        sz = 1;
      end
      sum += sz;
      nxt += sz;
    end
    check(l_op[1] == t.fop, {tg, " first opcode"}, l_op[1], t.fop);
    check(l_ad[1] == t.faddr[AW-1:0], {tg, " first address"}, l_ad[1], t.faddr);
    check(l_ln[1] == t.flen[XLW-1:0], {tg, " first length"}, l_ln[1], t.flen);
    check(l_ha[1] == (t.fop != OPC_CE && t.fop != OPC_WRSR), {tg, " R7 address flag"},
          l_ha[1], (t.fop != OPC_CE && t.fop != OPC_WRSR));
    base = (int'(t.ncmd) - 1) * 5 + 1;
    check(l_op[base] == t.lop, {tg, " last opcode"}, l_op[base], t.lop);
    check(l_ln[base] == t.llen[XLW-1:0], {tg, " last length"}, l_ln[base], t.llen);
    if (t.op != 2'd2)
      check(sum == longint'(t.len), {tg, " coverage"}, sum, t.len);
    if (wrdi)
      check(l_op[log_n-1] == OPC_WRDI, {tg, " R8 write disable last"}, l_op[log_n-1], OPC_WRDI);
  endtask

  // ---------------- main ----------------
  initial begin
    n_run = 0; n_fail = 0; log_n = 0; done_cnt = 0;
    rst_n = 1'b0; req_start = 1'b0; req_kind = 2'd0; req_addr = '0; req_len = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !xfer_req, "reset state", {busy, done, err, xfer_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !xfer_req, "reset idle after release", {busy, xfer_req}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      run_req(t.op, t.addr, t.len);
      analyze(t, v);
    end

    // R10: a second start while busy leaves no trace
    begin
      int dc0;
      dc0 = done_cnt;
      @(negedge clk);
      log_n = 0;
      req_kind = 2'd0; req_addr = 32'h10; req_len = 32'h200; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      repeat (4) @(negedge clk);
      check(busy == 1'b1, "R10 busy mid-sequence", busy, 1);
      req_kind = 2'd1; req_addr = 32'h0; req_len = DEV; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      while (!done) @(negedge clk);
      repeat (40) @(negedge clk);
      check(log_n == 16, "R10 traffic of first request only", log_n, 16);
      check(done_cnt - dc0 == 1, "R10 single done", done_cnt - dc0, 1);
      for (int i = 0; i < 16 && i < log_n; i++)
        check(l_op[i] != OPC_CE, "R10 no chip erase", l_op[i], 8'h38);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule